// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides the power state of a two-channel serial controller. It keeps a sleep depth of Active, Partial Sleep or Full Sleep, and lays a Power-Save overlay on top of the two sleep depths. From that state it drives an oscillator enable and a charge-pump enable. It also drives a gate that cuts the host bus off from the core logic, and a wake-up interrupt for the host. Sleep can be requested by a hardware pin or by a software bit. A chip-level pin can push an oscillator-stopped partial sleep down into full sleep. Falling edges on the serial receive lines, or a host access while the bus is not isolated, bring the block back to Active.

The oscillator and the charge pump are not modelled. Only their enables are produced here. When the charge pump is switched back on, a ready counter that software can load stands in for the pump's settling time. Partial Sleep stops only one resource, and that resource is chosen when sleep is entered. Once the block wakes, it stays awake until the sleep request has been dropped and raised again.

Top module: `lpm_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sleep_mode is 0 (Active), osc_en and pump_en are 1, pump_ready is 1, bus_iso is 0 and wake_irq is 0.
- R2: In Active, when sleep_pin or sleep_sw is high, the block is armed and no wake event is present, the next edge enters sleep. With full_sel=1 it enters Full Sleep (sleep_mode=2). With full_sel=0 it enters Partial Sleep (sleep_mode=1). In Partial Sleep, part_sel=0 turns off only osc_en and part_sel=1 turns off only pump_en. The choice is latched on entry.
- R3: In Full Sleep both osc_en and pump_en are 0.
- R4: In Partial Sleep with the oscillator stopped, acp_in=1 (with the request held and no wake event) moves the block to Full Sleep on the next edge. acp_in has no effect in a pump-stopped Partial Sleep.
- R5: bus_iso equals psave_pin AND (sleep_mode != 0). While bus_iso is 1, core_cs, core_rd, core_wr, core_addr and core_wdata are all 0. Otherwise they follow the host inputs.
- R6: A falling edge on any bit of rx_in wakes the block from either sleep depth. The input passes two synchronizer stages, so the block reaches Active at the third clock edge after the edge.
- R7: host_cs=1 while bus_iso=0 wakes the block at the next edge. host_cs=1 while bus_iso=1 leaves the sleep state unchanged.
- R8: Dropping the sleep request (both sleep_pin and sleep_sw low) during sleep returns to Active at the next edge. After any wake, sleep is re-entered only once the request has been low for at least one edge.
- R9: Every change from sleep to Active sets wake_irq at that edge. wake_irq stays set until irq_rd=1 at an edge with bus_iso=0 clears it. A new wake at the same edge wins over the clear.
- R10: When pump_en rises, pump_ready stays 0 for cfg_pump_wait clock cycles and then goes to 1. pump_ready is 0 whenever pump_en is 0.
- R11: Lowering psave_pin during sleep removes the isolation at once but does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_pin | input | 1 | Hardware sleep request |
| sleep_sw | input | 1 | Software sleep request bit |
| full_sel | input | 1 | 1: sleep request enters Full Sleep |
| part_sel | input | 1 | Partial Sleep resource: 0 oscillator, 1 charge pump |
| acp_in | input | 1 | Auto charge-pump sleep pin |
| psave_pin | input | 1 | Power-save overlay pin |
| rx_in | input | NCH (2) | Serial receive lines, idle high |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW (3) | Host address |
| host_wdata | input | DW (8) | Host data |
| irq_rd | input | 1 | Host read of the interrupt status |
| cfg_pump_wait | input | CW (12) | Charge-pump settle time in cycles |
| osc_en | output | 1 | Oscillator enable |
| pump_en | output | 1 | Charge-pump enable |
| pump_ready | output | 1 | Charge pump settled |
| bus_iso | output | 1 | Host bus isolated from core |
| wake_irq | output | 1 | Wake-up interrupt |
| sleep_mode | output | 2 | 0 Active, 1 Partial, 2 Full |
| core_cs | output | 1 | Gated chip select |
| core_rd | output | 1 | Gated read strobe |
| core_wr | output | 1 | Gated write strobe |
| core_addr | output | AW (3) | Gated address |
| core_wdata | output | DW (8) | Gated data |

## Verification
The bench targets the points where the sleep state meets its side conditions:

- A host access during power-save isolation must not wake the block. A design that wakes here would show sleep_mode 0 while bus_iso was 1.
- The auto pump-sleep pin must act only in an oscillator-stopped partial sleep. A pump-stopped partial sleep that wrongly reacts to it shows up as a bad sleep_mode.
- A receive edge must wake the block exactly at the third edge. A synchronizer of the wrong depth shows up as a wake one cycle early or late.
- The block must not fall asleep again while the request is still held after a wake.
- The interrupt set must take priority over the clear.
- The pump ready delay must be exact. An off-by-one shows up as pump_ready rising one cycle early or late.

Random sequences with a fixed seed then mix all inputs, and the outputs are compared on every cycle against a cycle model built from the requirements.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
package lpm_pkg;
    // Sleep depth; power-save is an overlay tracked separately.
    typedef enum logic [1:0] {
        LPM_ACTIVE  = 2'd0,
        LPM_PARTIAL = 2'd1,
        LPM_FULL    = 2'd2
    } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_detect.sv
// Wake source detector.
// Synchronizes the serial receive lines (idle high) through two stages and
// flags a falling edge on any line. Qualifies a host chip select with the
// bus-isolation state: an isolated host access is not a wake source.
// Assumes host_cs is already synchronous to clk.
module lpm_wake_detect #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rx_in,
    input  logic           host_cs,
    input  logic           bus_iso,
    output logic           rx_wake,
    output logic           host_wake
);
    logic [NCH-1:0] rx_s1, rx_s2, rx_s3;
    logic [NCH-1:0] fall;

    // Two-stage synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_s1 <= '1;
            rx_s2 <= '1;
            rx_s3 <= '1;
        end else begin
            rx_s1 <= rx_in;
            rx_s2 <= rx_s1;
            rx_s3 <= rx_s2;
        end
    end

    // Per-channel falling-edge flags.
    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_fall
            assign fall[ch] = rx_s3[ch] & ~rx_s2[ch];
        end
    endgenerate

    // Combine wake sources.
    always_comb begin
        rx_wake   = |fall;
        host_wake = host_cs & ~bus_iso;
    end
endmodule

// File: rtl/lpm_mode_fsm.sv
// Sleep-depth state machine and wake interrupt.
// Enters Partial or Full Sleep on an armed request, promotes an
// oscillator-stopped partial sleep to full sleep on the auto pump-sleep pin,
// returns to Active on a wake event or a dropped request, and raises the wake
// interrupt on every exit. Assumes all inputs are synchronous to clk.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      full_sel,
    input  logic      part_sel,
    input  logic      acp_in,
    input  logic      psave_pin,
    input  logic      rx_wake,
    input  logic      host_wake,
    input  logic      irq_rd,
    output lpm_mode_e mode,
    output logic      osc_en,
    output logic      pump_en,
    output logic      bus_iso,
    output logic      wake_irq
);
    lpm_mode_e mode_q, mode_d;
    logic      part_pump_q, part_pump_d;
    logic      armed_q;
    logic      irq_q;
    logic      wake;
    logic      exiting;

    // Next-state decision for the sleep depth.
    always_comb begin
        wake        = rx_wake | host_wake;
        mode_d      = mode_q;
        part_pump_d = part_pump_q;
        unique case (mode_q)
            LPM_ACTIVE: begin
                if (sleep_req && armed_q && !wake) begin
                    if (full_sel) begin
                        mode_d = LPM_FULL;
                    end else begin
                        mode_d      = LPM_PARTIAL;
                        part_pump_d = part_sel;
                    end
                end
            end
            LPM_PARTIAL: begin
                if (wake || !sleep_req)        mode_d = LPM_ACTIVE;
                else if (!part_pump_q && acp_in) mode_d = LPM_FULL;
            end
            LPM_FULL: begin
                if (wake || !sleep_req) mode_d = LPM_ACTIVE;
            end
            default: mode_d = LPM_ACTIVE;
        endcase
        exiting = (mode_q != LPM_ACTIVE) && (mode_d == LPM_ACTIVE);
    end

    // State, arming and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= LPM_ACTIVE;
            part_pump_q <= 1'b0;
            armed_q     <= 1'b1;
            irq_q       <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            part_pump_q <= part_pump_d;
            if (exiting)         armed_q <= 1'b0;
            else if (!sleep_req) armed_q <= 1'b1;
            if (exiting)                  irq_q <= 1'b1;
            else if (irq_rd && !bus_iso)  irq_q <= 1'b0;
        end
    end

    // Resource enables and isolation derived from the current state.
    always_comb begin
        mode     = mode_q;
        osc_en   = !((mode_q == LPM_FULL) || ((mode_q == LPM_PARTIAL) && !part_pump_q));
        pump_en  = !((mode_q == LPM_FULL) || ((mode_q == LPM_PARTIAL) && part_pump_q));
        bus_iso  = psave_pin && (mode_q != LPM_ACTIVE);
        wake_irq = irq_q;
    end

    AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LPM_ACTIVE && sleep_req && armed_q && !wake) |=> (mode_q != LPM_ACTIVE)); // R2
    AST_ACP_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LPM_PARTIAL && !osc_en && acp_in && sleep_req && !wake) |=> (mode_q == LPM_FULL)); // R4
    AST_ISO_NO_HOST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != LPM_ACTIVE && bus_iso && !rx_wake && sleep_req) |=> (mode_q != LPM_ACTIVE)); // R7
    AST_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) != LPM_ACTIVE && mode_q == LPM_ACTIVE) |-> wake_irq); // R9
    AST_FULL_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LPM_FULL) |-> (!osc_en && !pump_en)); // R3
endmodule

// File: rtl/lpm_pump_timer.sv
// Charge-pump settle counter.
// While the pump is off the counter holds the programmed wait; once the pump
// is enabled it counts down and ready rises when it reaches zero.
// Assumes cfg_wait is held stable while a countdown runs.
module lpm_pump_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pump_en,
    input  logic [CW-1:0] cfg_wait,
    output logic          pump_ready
);
    logic [CW-1:0] cnt_q;

    // Load while off, count down while on.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!pump_en)       cnt_q <= cfg_wait;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Ready only when enabled and settled.
    assign pump_ready = pump_en && (cnt_q == '0);

    AST_PUMP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pump_en) && cfg_wait != '0 && $past(cfg_wait) == cfg_wait) |-> !pump_ready); // R10
    AST_READY_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        pump_ready |-> pump_en); // R10
endmodule

// File: rtl/lpm_bus_gate.sv
// Host bus isolation gate.
// Forces chip select, strobes, address and data seen by the core to zero
// while isolation is active; passes them unchanged otherwise.
module lpm_bus_gate #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          bus_iso,
    input  logic          host_cs,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          core_cs,
    output logic          core_rd,
    output logic          core_wr,
    output logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_wdata
);
    // Gate every host signal with the isolation state.
    always_comb begin
        core_cs    = host_cs & ~bus_iso;
        core_rd    = host_rd & ~bus_iso;
        core_wr    = host_wr & ~bus_iso;
        core_addr  = bus_iso ? '0 : host_addr;
        core_wdata = bus_iso ? '0 : host_wdata;
    end
endmodule

// File: rtl/lpm_sequencer.sv
// Low-power mode sequencer, top level.
// Merges the hardware and software sleep requests, then ties together the
// wake detector, the mode state machine, the pump settle timer and the host
// bus gate. Assumes every input is synchronous to clk except rx_in.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int CW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep_pin,
    input  logic           sleep_sw,
    input  logic           full_sel,
    input  logic           part_sel,
    input  logic           acp_in,
    input  logic           psave_pin,
    input  logic [NCH-1:0] rx_in,
    input  logic           host_cs,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic [AW-1:0]  host_addr,
    input  logic [DW-1:0]  host_wdata,
    input  logic           irq_rd,
    input  logic [CW-1:0]  cfg_pump_wait,
    output logic           osc_en,
    output logic           pump_en,
    output logic           pump_ready,
    output logic           bus_iso,
    output logic           wake_irq,
    output logic [1:0]     sleep_mode,
    output logic           core_cs,
    output logic           core_rd,
    output logic           core_wr,
    output logic [AW-1:0]  core_addr,
    output logic [DW-1:0]  core_wdata
);
    logic      sleep_req;
    logic      rx_wake;
    logic      host_wake;
    lpm_mode_e mode;

    // Either request source asks for sleep.
    assign sleep_req  = sleep_pin | sleep_sw;
    assign sleep_mode = mode;

    lpm_wake_detect #(.NCH(NCH)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .host_cs   (host_cs),
        .bus_iso   (bus_iso),
        .rx_wake   (rx_wake),
        .host_wake (host_wake)
    );

    lpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .full_sel  (full_sel),
        .part_sel  (part_sel),
        .acp_in    (acp_in),
        .psave_pin (psave_pin),
        .rx_wake   (rx_wake),
        .host_wake (host_wake),
        .irq_rd    (irq_rd),
        .mode      (mode),
        .osc_en    (osc_en),
        .pump_en   (pump_en),
        .bus_iso   (bus_iso),
        .wake_irq  (wake_irq)
    );

    lpm_pump_timer #(.CW(CW)) u_pump (
        .clk        (clk),
        .rst_n      (rst_n),
        .pump_en    (pump_en),
        .cfg_wait   (cfg_pump_wait),
        .pump_ready (pump_ready)
    );

    lpm_bus_gate #(.AW(AW), .DW(DW)) u_gate (
        .bus_iso    (bus_iso),
        .host_cs    (host_cs),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .core_cs    (core_cs),
        .core_rd    (core_rd),
        .core_wr    (core_wr),
        .core_addr  (core_addr),
        .core_wdata (core_wdata)
    );

    AST_ISO_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iso |-> (core_cs == 1'b0 && core_addr == '0 && core_wdata == '0)); // R5
    AST_ISO_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iso |-> (sleep_mode != 2'd0 && psave_pin)); // R5
endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    localparam int NCH = 2;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int CW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_pin = 0, sleep_sw = 0, full_sel = 0, part_sel = 0;
    logic acp_in = 0, psave_pin = 0, host_cs = 0, host_rd = 0, host_wr = 0, irq_rd = 0;
    logic [NCH-1:0] rx_in = '1;
    logic [AW-1:0]  host_addr = '0;
    logic [DW-1:0]  host_wdata = '0;
    logic [CW-1:0]  cfg_pump_wait = 12'd5;
    logic osc_en, pump_en, pump_ready, bus_iso, wake_irq;
    logic [1:0] sleep_mode;
    logic core_cs, core_rd, core_wr;
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Cycle model state derived from the requirements.
    int          m_mode;
    bit          m_part, m_arm, m_irq;
    logic [NCH-1:0] m_rx1, m_rx2, m_rx3;
    int          m_cnt;

    always #4 clk = ~clk;

    lpm_sequencer #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .sleep_sw(sleep_sw),
        .full_sel(full_sel), .part_sel(part_sel), .acp_in(acp_in),
        .psave_pin(psave_pin), .rx_in(rx_in), .host_cs(host_cs),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .irq_rd(irq_rd), .cfg_pump_wait(cfg_pump_wait),
        .osc_en(osc_en), .pump_en(pump_en), .pump_ready(pump_ready),
        .bus_iso(bus_iso), .wake_irq(wake_irq), .sleep_mode(sleep_mode),
        .core_cs(core_cs), .core_rd(core_rd), .core_wr(core_wr),
        .core_addr(core_addr), .core_wdata(core_wdata)
    );

    function automatic bit exp_osc();
        return !(m_mode == 2 || (m_mode == 1 && !m_part));
    endfunction
    function automatic bit exp_pump();
        return !(m_mode == 2 || (m_mode == 1 && m_part));
    endfunction
    function automatic bit exp_iso();
        return psave_pin && (m_mode != 0);
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs present at that edge.
    task automatic model_edge();
        bit fall, iso, wake, req, ex, pe;
        int nxt;
        if (!rst_n) begin
            m_mode = 0; m_part = 0; m_arm = 1; m_irq = 0;
            m_rx1 = '1; m_rx2 = '1; m_rx3 = '1; m_cnt = 0;
            return;
        end
        fall = |(m_rx3 & ~m_rx2);
        iso  = exp_iso();
        wake = fall || (host_cs && !iso);
        req  = sleep_pin || sleep_sw;
        pe   = exp_pump();
        nxt  = m_mode;
        if (m_mode == 0) begin
            if (req && m_arm && !wake) begin
                if (full_sel) nxt = 2;
                else begin nxt = 1; m_part = part_sel; end
            end
        end else if (wake || !req) nxt = 0;
        else if (m_mode == 1 && !m_part && acp_in) nxt = 2;
        ex = (m_mode != 0) && (nxt == 0);
        if (ex) m_arm = 0; else if (!req) m_arm = 1;
        if (ex) m_irq = 1; else if (irq_rd && !iso) m_irq = 0;
        if (!pe) m_cnt = int'(cfg_pump_wait); else if (m_cnt != 0) m_cnt--;
        m_mode = nxt;
        m_rx3 = m_rx2; m_rx2 = m_rx1; m_rx1 = rx_in;
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        chk(int'(sleep_mode), m_mode, "R2 sleep_mode");
        chk(int'(osc_en), int'(exp_osc()), "R3 osc_en");
        chk(int'(pump_en), int'(exp_pump()), "R3 pump_en");
        chk(int'(pump_ready), int'(exp_pump() && m_cnt == 0), "R10 pump_ready");
        chk(int'(wake_irq), int'(m_irq), "R9 wake_irq");
        chk(int'(bus_iso), int'(exp_iso()), "R5 bus_iso");
        chk(int'(core_cs), int'(host_cs && !exp_iso()), "R5 core_cs");
        chk(int'(core_wdata), exp_iso() ? 0 : int'(host_wdata), "R5 core_wdata");
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk(int'(sleep_mode), 0, "R1 mode");
        chk(int'(osc_en & pump_en & pump_ready), 1, "R1 enables");
        chk(int'(bus_iso | wake_irq), 0, "R1 iso/irq");
        tick();
        // R2 partial sleep with oscillator stopped
        sleep_sw = 1; part_sel = 0; tick();
        chk(int'(sleep_mode), 1, "R2 partial");
        chk(int'({osc_en, pump_en}), 1, "R2 osc only off");
        // R4 promotion
        acp_in = 1; tick(); acp_in = 0;
        chk(int'(sleep_mode), 2, "R4 promote");
        chk(int'({osc_en, pump_en}), 0, "R3 both off");
        // R5/R7 isolated host access ignored
        psave_pin = 1; tick();
        chk(int'(bus_iso), 1, "R5 isolated");
        host_cs = 1; host_rd = 1; host_wdata = 8'hA5;
        @(negedge clk);
        chk(int'(core_cs), 0, "R5 cs blocked");
        chk(int'(core_wdata), 0, "R5 data blocked");
        tick(); tick();
        chk(int'(sleep_mode), 2, "R7 isolated host no wake");
        host_cs = 0; host_rd = 0;
        // R11 dropping psave removes isolation, no wake
        psave_pin = 0; tick();
        chk(int'(bus_iso), 0, "R11 iso removed");
        chk(int'(sleep_mode), 2, "R11 still asleep");
        psave_pin = 1;
        // R6 receive edge wakes at third edge
        rx_in[1] = 0; tick(); tick();
        chk(int'(sleep_mode), 2, "R6 not yet");
        tick();
        chk(int'(sleep_mode), 0, "R6 woke");
        chk(int'(wake_irq), 1, "R9 irq set");
        chk(int'(pump_ready), 0, "R10 settling");
        rx_in[1] = 1;
        // R8 no re-entry while request held; R10 exact delay (wait=5)
        repeat (4) tick();
        chk(int'(sleep_mode), 0, "R8 no re-entry");
        chk(int'(pump_ready), 0, "R10 before wait");
        tick();
        chk(int'(pump_ready), 1, "R10 after wait");
        // R9 clear by status read
        irq_rd = 1; tick(); irq_rd = 0;
        chk(int'(wake_irq), 0, "R9 cleared");
        // R2 pump-stopped partial, R4 acp ignored there
        sleep_sw = 0; tick();
        sleep_sw = 1; part_sel = 1; psave_pin = 0; tick();
        chk(int'({osc_en, pump_en}), 2, "R2 pump only off");
        acp_in = 1; tick(); acp_in = 0;
        chk(int'(sleep_mode), 1, "R4 ignored when osc runs");
        // R7 host access wakes when not isolated
        host_cs = 1; tick(); host_cs = 0;
        chk(int'(sleep_mode), 0, "R7 host wake");
        // R2 hardware pin to full, R8 drop request exits
        sleep_sw = 0; tick();
        sleep_pin = 1; full_sel = 1; tick();
        chk(int'(sleep_mode), 2, "R2 full via pin");
        sleep_pin = 0; tick();
        chk(int'(sleep_mode), 0, "R8 drop exits");
        chk(int'(wake_irq), 1, "R9 irq on drop exit");
        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            sleep_pin  = ($urandom % 8) != 0;
            sleep_sw   = ($urandom % 4) == 0;
            full_sel   = ($urandom % 3) == 0;
            part_sel   = $urandom % 2;
            acp_in     = ($urandom % 4) == 0;
            psave_pin  = ($urandom % 2);
            host_cs    = ($urandom % 16) == 0;
            host_rd    = $urandom % 2;
            host_wr    = $urandom % 2;
            host_addr  = AW'($urandom);
            host_wdata = DW'($urandom);
            irq_rd     = ($urandom % 8) == 0;
            for (int c = 0; c < NCH; c++)
                if (($urandom % 16) == 0) rx_in[c] = ~rx_in[c];
            if (!pump_en && ($urandom % 32) == 0) cfg_pump_wait = CW'($urandom % 20);
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule